// File: doc/BRIEF.md
# Variable-Precision Quadratic Function Interpolator

This block approximates one of four elementary functions (base-2 exponential, base-2 logarithm, reciprocal and reciprocal square root) over the significand of a 32-bit single-precision operand. The significand is split in two. The upper bits pick a segment, and the lower bits form a fraction `x`. Each function has its own coefficient table, which returns three coefficients for the chosen segment. A short pipeline then computes `C0 ± C1·x + C2·x²`. A dedicated squarer produces `x²`, and both products come from radix-4 recoded multipliers that sum their rows in carry-save form.

A 2-bit precision mode trades accuracy for switching activity. In the two reduced modes the low fraction bits are cleared before they reach the squarer and the multipliers. The low result bits are also blocked: their pipeline register is not loaded, and those bits read as zero at the output. Each table keeps its index in its own register, and only the table of the selected function loads it. The other three tables see no input change.

The coefficients are simple placeholder formulas of the segment number and the function code. Range reduction and exponent handling are left to the surrounding datapath.

Top module: `quadFuncInterp`

## Requirements
- R1: With full precision, the result is `(C0 + T1 + T2) mod 2^23` for functions 0 (exp2) and 1 (log2), and `(C0 − T1 + T2) mod 2^23` for functions 2 (reciprocal) and 3 (reciprocal square root). Here `T1 = (C1·x) >> XW`, `S = (x·x) >> XW` and `T2 = (C2·S) >> XW`. The table formulas are `C0 = (seg << XW) + 4096·(f+1)` mod 2^23, `C1 = 16384 + 512·f + 64·seg` and `C2 = 64·(f+1) + seg`, where `f` is the function code.
- R2: The segment `seg` is significand bits [22:XW] (IDX_W bits), and `x` is significand bits [XW−1:0], with `XW = 23 − IDX_W`. The significand is operand bits [22:0].
- R3: Operand bits [31:23] (sign and exponent) have no effect on the result.
- R4: The function select may change on every cycle. Each result uses only its own function's table. At most one table index register loads per cycle, and the others hold their value.
- R5: The precision mode is encoded as 0 = full, 1 = 16-bit, 2 = 8-bit and 3 = full. Mode 1 clears the low 7 bits of `x` before evaluation, and mode 2 clears the low 15 bits.
- R6: A result computed in mode 1 has output bits [6:0] equal to zero. A result computed in mode 2 has output bits [14:0] equal to zero.
- R7: `outValid` rises exactly three clock edges after an accepted `inValid`. Operands may be given on every cycle, and each one produces exactly one result, in order.
- R8: While reset is held, and after it is released, `outValid` is 0 until the first operand has passed through the pipeline.
- R9: On every cycle with `outValid` low, `outSig` keeps the value it had on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand and selects are valid this cycle |
| opIn | input | 32 | Single-precision operand; only the significand is used |
| funcSel | input | 2 | 0 exp2, 1 log2, 2 reciprocal, 3 reciprocal square root |
| precMode | input | 2 | 0 full, 1 16-bit, 2 8-bit, 3 full |
| outValid | output | 1 | Result valid |
| outSig | output | 23 | Approximated result significand |

## Verification
The assertions check the following properties on every cycle:
- The three-cycle valid latency, with no spurious results.
- At most one table loads at a time, and the unselected tables stay still.
- The stage-one fraction register carries no bits below the selected precision.
- Reduced-mode results come out with zeroed low bits.
- The output holds between results.

The arithmetic itself can only be shown by the bench's scenarios. The bench sweeps every segment, function and mode of a 4-bit-index configuration against a fraction set that includes zero, one, all-ones and alternating patterns. It also covers back-to-back function changes and operands whose upper bits differ.

// File: rtl/quadInterpPkg.sv
package quadInterpPkg;
  localparam int SIG_W    = 23;
  localparam int OP_W     = 32;
  localparam int NUM_FUNC = 4;
  localparam int MID_KEEP = 16;
  localparam int LOW_KEEP = 8;

  typedef enum logic [1:0] {FN_EXP2, FN_LOG2, FN_RECIP, FN_RSQRT} funcSel_t;
  typedef enum logic [1:0] {PM_FULL, PM_MID, PM_LOW, PM_ALT} precMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FUNC-1:0] tblLoad;
    logic                s1Load;
    logic                s2Load;
    logic                s3Load;
    logic                s3LowLoad;
    precMode_t           inMode;
    funcSel_t            funcS1;
    logic                negS2;
    precMode_t           modeS3;
  } ctrlStrobes_t;

  function automatic int dropBits(precMode_t m);
    case (m)
      PM_MID:  return SIG_W - MID_KEEP;
      PM_LOW:  return SIG_W - LOW_KEEP;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/coefTable.sv
module coefTable import quadInterpPkg::*; #(
  parameter int FUNC_ID = 0,
  parameter int IDX_W   = 7,
  parameter int C1_W    = 16,
  parameter int C2_W    = 10,
  localparam int XW     = SIG_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] idxIn,
  output logic [SIG_W-1:0] c0,
  output logic [C1_W-1:0]  c1,
  output logic [C2_W-1:0]  c2
);
  // index held while this function is not selected: table inputs stay quiet
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (rst)       idxQ <= '0;
    else if (load) idxQ <= idxIn;
  end

  // placeholder fit, computed rather than stored
  always_comb begin
    c0 = SIG_W'((int'(idxQ) << XW) + 4096 * (FUNC_ID + 1));
    c1 = C1_W'(16384 + 512 * FUNC_ID + 64 * int'(idxQ));
    c2 = C2_W'(64 * (FUNC_ID + 1) + int'(idxQ));
  end
endmodule

// File: rtl/interpSquarer.sv
module interpSquarer #(
  parameter int W = 16,
  localparam int SW = 2 * W
) (
  input  logic [W-1:0]  a,
  output logic [SW-1:0] sq
);
  // folded square: diagonal terms plus doubled cross terms
  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) acc = acc + (SW'(1) << (2 * i));
      for (int j = i + 1; j < W; j++) begin
        if (a[i] && a[j]) acc = acc + (SW'(1) << (i + j + 1));
      end
    end
    sq = acc;
  end
endmodule

// File: rtl/boothMul.sv
module boothMul #(
  parameter int AW = 16,
  parameter int BW = 16,
  localparam int PW  = AW + BW,
  localparam int NPP = (BW + 2) / 2
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] p
);
  logic [2*NPP:0] bExt;
  logic [PW-1:0]  pp [NPP];

  assign bExt = {{(2*NPP-BW){1'b0}}, b, 1'b0};

  // radix-4 recoded rows, two's complement modulo 2^PW
  for (genvar k = 0; k < NPP; k++) begin : g_row
    logic [2:0]    grp;
    logic [PW-1:0] mag;
    assign grp = bExt[2*k+2:2*k];
    always_comb begin
      case (grp)
        3'b001, 3'b010: mag = PW'(a);
        3'b011:         mag = PW'(a) << 1;
        3'b100:         mag = -(PW'(a) << 1);
        3'b101, 3'b110: mag = -PW'(a);
        default:        mag = '0;
      endcase
    end
    assign pp[k] = mag << (2 * k);
  end

  // carry-save accumulation, one carry-propagate add at the end
  always_comb begin
    logic [PW-1:0] s, c, ns, nc;
    s = pp[0];
    c = '0;
    for (int k = 1; k < NPP; k++) begin
      ns = s ^ c ^ pp[k];
      nc = ((s & c) | (s & pp[k]) | (c & pp[k])) << 1;
      s  = ns;
      c  = nc;
    end
    p = s + c;
  end
endmodule

// File: rtl/interpCtrl.sv
module interpCtrl import quadInterpPkg::*; (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  funcSel_t     funcIn,
  input  precMode_t    modeIn,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  logic      v1, v2, v3;
  funcSel_t  f1, f2;
  precMode_t m1, m2, m3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      f1 <= FN_EXP2; f2 <= FN_EXP2;
      m1 <= PM_FULL; m2 <= PM_FULL; m3 <= PM_FULL;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (inValid) begin f1 <= funcIn; m1 <= modeIn; end
      if (v1)      begin f2 <= f1;     m2 <= m1;     end
      if (v2)      m3 <= m2;
    end
  end

  always_comb begin
    strobes = '0;
    for (int k = 0; k < NUM_FUNC; k++)
      strobes.tblLoad[k] = inValid && (int'(funcIn) == k);
    strobes.s1Load    = inValid;
    strobes.s2Load    = v1;
    strobes.s3Load    = v2;
    strobes.s3LowLoad = v2 && (dropBits(m2) == 0);
    strobes.inMode    = modeIn;
    strobes.funcS1    = f1;
    strobes.negS2     = (f2 == FN_RECIP) || (f2 == FN_RSQRT);
    strobes.modeS3    = m3;
  end

  assign outValid = v3;

  p_one_table_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.tblLoad));
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##3 !outValid);
  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/interpDatapath.sv
module interpDatapath import quadInterpPkg::*; #(
  parameter int IDX_W = 7,
  parameter int C1_W  = 16,
  parameter int C2_W  = 10,
  localparam int XW   = SIG_W - IDX_W,
  localparam int LO_W = SIG_W - MID_KEEP
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [SIG_W-1:0] sigIn,
  output logic [SIG_W-1:0] sigOut
);
  function automatic logic [XW-1:0] xKeep(precMode_t m);
    logic [XW-1:0] k;
    for (int i = 0; i < XW; i++) k[i] = (i >= dropBits(m));
    return k;
  endfunction

  function automatic logic [SIG_W-1:0] rKeep(precMode_t m);
    logic [SIG_W-1:0] k;
    for (int i = 0; i < SIG_W; i++) k[i] = (i >= dropBits(m));
    return k;
  endfunction

  // stage 1: truncated fraction, per-function table index registers
  logic [XW-1:0] xS1;
  always_ff @(posedge clk) begin
    if (rst)                 xS1 <= '0;
    else if (strobes.s1Load) xS1 <= sigIn[XW-1:0] & xKeep(strobes.inMode);
  end

  logic [SIG_W-1:0] c0Arr [NUM_FUNC];
  logic [C1_W-1:0]  c1Arr [NUM_FUNC];
  logic [C2_W-1:0]  c2Arr [NUM_FUNC];

  for (genvar k = 0; k < NUM_FUNC; k++) begin : g_tbl
    coefTable #(.FUNC_ID(k), .IDX_W(IDX_W), .C1_W(C1_W), .C2_W(C2_W)) u_tbl (
      .clk   (clk),
      .rst   (rst),
      .load  (strobes.tblLoad[k]),
      .idxIn (sigIn[SIG_W-1:XW]),
      .c0    (c0Arr[k]),
      .c1    (c1Arr[k]),
      .c2    (c2Arr[k])
    );
    p_table_static_r4: assert property (@(posedge clk) disable iff (rst)
      !strobes.tblLoad[k] |=> $stable(c0Arr[k]) && $stable(c2Arr[k]));
  end

  logic [SIG_W-1:0]   c0Sel;
  logic [C1_W-1:0]    c1Sel;
  logic [C2_W-1:0]    c2Sel;
  logic [2*XW-1:0]    sqFull;
  logic [C1_W+XW-1:0] prod1;

  assign c0Sel = c0Arr[strobes.funcS1];
  assign c1Sel = c1Arr[strobes.funcS1];
  assign c2Sel = c2Arr[strobes.funcS1];

  interpSquarer #(.W(XW)) u_sq (.a(xS1), .sq(sqFull));
  boothMul #(.AW(C1_W), .BW(XW)) u_mulLin (.a(c1Sel), .b(xS1), .p(prod1));

  // stage 2: constant, quadratic coefficient, kept square, linear term
  logic [SIG_W-1:0] c0S2;
  logic [C2_W-1:0]  c2S2;
  logic [XW-1:0]    sqS2;
  logic [C1_W-1:0]  t1S2;

  always_ff @(posedge clk) begin
    if (rst) begin
      c0S2 <= '0; c2S2 <= '0; sqS2 <= '0; t1S2 <= '0;
    end else if (strobes.s2Load) begin
      c0S2 <= c0Sel;
      c2S2 <= c2Sel;
      sqS2 <= sqFull[2*XW-1:XW];
      t1S2 <= prod1[C1_W+XW-1:XW];
    end
  end

  logic [C2_W+XW-1:0] prod2;
  logic [SIG_W-1:0]   sumS2;

  boothMul #(.AW(C2_W), .BW(XW)) u_mulQuad (.a(c2S2), .b(sqS2), .p(prod2));

  always_comb begin
    if (strobes.negS2) sumS2 = c0S2 - SIG_W'(t1S2) + SIG_W'(prod2[C2_W+XW-1:XW]);
    else               sumS2 = c0S2 + SIG_W'(t1S2) + SIG_W'(prod2[C2_W+XW-1:XW]);
  end

  // stage 3: low bits load only at full precision (clock-enable gating)
  logic [MID_KEEP-1:0] resHi;
  logic [LO_W-1:0]     resLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      resHi <= '0;
      resLo <= '0;
    end else begin
      if (strobes.s3Load)    resHi <= sumS2[SIG_W-1:LO_W];
      if (strobes.s3LowLoad) resLo <= sumS2[LO_W-1:0];
    end
  end

  assign sigOut = {resHi, resLo} & rKeep(strobes.modeS3);

  logic unusedLow;
  assign unusedLow = ^{sqFull[XW-1:0], prod1[XW-1:0], prod2[XW-1:0]};

  p_x_trunc_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.s1Load |=> (xS1 & ~xKeep($past(strobes.inMode))) == '0);
endmodule

// File: rtl/quadFuncInterp.sv
module quadFuncInterp import quadInterpPkg::*; #(
  parameter int IDX_W = 7,
  parameter int C1_W  = 16,
  parameter int C2_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opIn,
  input  logic [1:0]       funcSel,
  input  logic [1:0]       precMode,
  output logic             outValid,
  output logic [SIG_W-1:0] outSig
);
  ctrlStrobes_t strobes;
  logic         unusedUpper;

  assign unusedUpper = ^opIn[OP_W-1:SIG_W];

  interpCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .funcIn   (funcSel_t'(funcSel)),
    .modeIn   (precMode_t'(precMode)),
    .strobes  (strobes),
    .outValid (outValid)
  );

  interpDatapath #(.IDX_W(IDX_W), .C1_W(C1_W), .C2_W(C2_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .sigIn   (opIn[SIG_W-1:0]),
    .sigOut  (outSig)
  );

  p_mask_mid_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && precMode == 2'd1) |-> ##3 (outSig[SIG_W-MID_KEEP-1:0] == '0));
  p_mask_low_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && precMode == 2'd2) |-> ##3 (outSig[SIG_W-LOW_KEEP-1:0] == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSig));
endmodule

// File: tb/quadFuncInterp_bench.sv
module quadFuncInterp_bench;
  localparam int IDX_B = 4;
  localparam int XW_B  = 23 - IDX_B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] opIn = '0;
  logic [1:0]  funcSel = '0;
  logic [1:0]  precMode = '0;
  logic        outValid;
  logic [22:0] outSig;

  int tests = 0;
  int fails = 0;
  logic [22:0] expQ[$];
  int          modeQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  quadFuncInterp #(.IDX_W(IDX_B)) u_quadFuncInterp (
    .clk(clk), .rst(rst), .inValid(inValid), .opIn(opIn),
    .funcSel(funcSel), .precMode(precMode),
    .outValid(outValid), .outSig(outSig)
  );

  function automatic logic [22:0] model(int f, int m, logic [22:0] sig);
    longint seg, x, c0, c1, c2, sq, t1, t2, r;
    int drop;
    drop = (m == 1) ? 7 : ((m == 2) ? 15 : 0);
    seg = longint'(sig >> XW_B);
    x   = longint'(sig) & ((64'sd1 << XW_B) - 1);
    x   = (x >> drop) << drop;
    c0  = ((seg << XW_B) + 4096 * (f + 1)) & 64'sh7FFFFF;
    c1  = 16384 + 512 * f + 64 * seg;
    c2  = 64 * (f + 1) + seg;
    sq  = (x * x) >> XW_B;
    t1  = (c1 * x) >> XW_B;
    t2  = (c2 * sq) >> XW_B;
    r   = (f >= 2) ? (c0 - t1 + t2) : (c0 + t1 + t2);
    r   = r & 64'sh7FFFFF;
    r   = (r >> drop) << drop;
    return r[22:0];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one operand for one cycle; caller is aligned to a negedge
  task automatic sendOp(input int f, input int m, input logic [22:0] sig,
                        input logic [8:0] upper, input string tag);
    inValid  = 1'b1;
    funcSel  = 2'(f);
    precMode = 2'(m);
    opIn     = {upper, sig};
    expQ.push_back(model(f, m, sig));
    modeQ.push_back(m);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // scoreboard: in-order results, low-bit zeroing in reduced modes
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected result", outSig, 0);
      end else begin
        logic [22:0] e;
        int m;
        string t;
        e = expQ.pop_front();
        m = modeQ.pop_front();
        t = tagQ.pop_front();
        check(outSig == e, t, outSig, e);
        if (m == 1) check(outSig[6:0] == '0, "R6 mid mode low bits", outSig[6:0], 0);
        if (m == 2) check(outSig[14:0] == '0, "R6 low mode low bits", outSig[14:0], 0);
      end
    end
  end

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [22:0] xs [6];
    logic [22:0] lastSig;
    xs[0] = 23'h0; xs[1] = 23'h1; xs[2] = 23'h7FFFF;
    xs[3] = 23'h2AAAA; xs[4] = 23'h55555; xs[5] = 23'h40000;

    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 outValid in reset", outValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8 outValid after reset", outValid, 0);

    // R7 latency: single operand, visible on the third edge only
    sendOp(2, 0, 23'h3_2345, 9'h0AB, "R1 single reciprocal");
    inValid = 1'b0;
    check(outValid == 1'b0, "R7 edge 1", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R7 edge 2", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R7 edge 3", outValid, 1);
    lastSig = outSig;

    // R9 hold while idle
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R9 idle valid", outValid, 0);
    check(outSig == lastSig, "R9 idle hold", outSig, lastSig);

    // R3: sign/exponent bits differ, same significand
    sendOp(0, 0, 23'h5_1234, 9'h000, "R3 upper zero");
    sendOp(0, 0, 23'h5_1234, 9'h1FF, "R3 upper ones");
    sendOp(1, 1, 23'h6_ABCD, 9'h155, "R3 upper mixed");
    // R4: function changes every cycle, same significand
    for (int f = 0; f < 4; f++) sendOp(f, 0, 23'h7_7777, 9'h080, "R4 interleaved tables");
    // R5: mode 3 behaves as full
    sendOp(3, 3, 23'h1_FFFF, 9'h001, "R5 mode 3 full");

    // R2/R1/R5 sweep: every segment, function and mode, back to back
    for (int seg = 0; seg < (1 << IDX_B); seg++) begin
      for (int xi = 0; xi < 6; xi++) begin
        for (int m = 0; m < 4; m++) begin
          for (int f = 0; f < 4; f++) begin
            logic [22:0] sig;
            sig = {4'(seg), xs[xi][18:0]};
            sendOp(f, m, sig, 9'((seg * 37 + f) & 9'h1FF),
                   (m == 1 || m == 2) ? "R5 reduced sweep" : "R1 R2 full sweep");
          end
        end
      end
    end
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R7 every operand produced a result", expQ.size(), 0);
    finishRun();
  end
endmodule